// File: doc/BRIEF.md
# Stretchable External Memory Bus Sequencer

This block runs one read or write access at a time on an external data-memory bus. The bus multiplexes the low address byte and the data byte on one shared 8-bit port, and the high address byte has a separate port. The block drives an address-latch strobe and two active-low strobes, one for reads and one for writes. On the internal side a single-clock request carries a read/write flag, a 16-bit address and a write byte. The block returns the read byte and a one-clock completion pulse.

The block's clock runs at twice the bus clock rate, so one clock period of `clk` is one half-bus-clock phase. Every bus edge therefore lands on a whole phase. A 3-bit stretch setting S selects how long an access takes. An access lasts S+2 machine cycles of 8 phases each, so S=0 gives 2 machine cycles and S=7 gives 9. The setting also chooses between two timing profiles. S=0 selects a tight profile. Any nonzero S selects a relaxed profile, in which the strobe stays low for the full stretch time and the address, setup and hold windows are wider.

Phase k of an access is the k-th `clk` period after the rising edge that accepted the request. Phase 0 is the period right after that edge. L = 8·(S+2) is the access length in phases.

Top module: `bus_stretch_seq`

## Requirements
- R1: `busy` stays high for exactly L = 8·(S+2) consecutive clock periods per access. Here S is the stretch setting captured at the start of the access, so S=0 gives 16 periods and S=7 gives 72.
- R2: `ale` is high from phase 0. It is high for 3 phases when S=0 and for 4 phases when S>0. `ale` is never high while a strobe is low.
- R3: The strobe falls at phase 4 when S=0 and at phase 6 when S>0. It then stays low for 4 phases when S=0 and for 8·S phases when S>0. A read drives only `rd_n` low, a write drives only `wr_n` low, and both strobes are never low together.
- R4: `a_hi` carries address bits 15:8 from phase 1 through the last phase and is 0 otherwise. The shared port drives address bits 7:0 with `ad_oe`=1 from phase 2 until the phase in which the strobe falls.
- R5: On a write, the shared port drives the write byte from the strobe-fall phase. It keeps driving it until 2 phases after the strobe rises when S=0, or 4 phases after when S>0. Outside the windows of R4 and R5, `ad_oe` is 0 and `ad_o` is 0.
- R6: On a read, the shared port is undriven for as long as `rd_n` is low. `rdata` loads `ad_i` at the clock edge that ends the last low phase of `rd_n`, and it holds that value until the next read captures.
- R7: `done` is high for exactly one clock, in the last phase of the access. `busy` is high in every phase of an access, and while idle all strobes are inactive and the port is undriven.
- R8: A request that arrives while busy is ignored. The inputs `we`, `addr` and `wdata` are captured only at the accepting edge, and an idle request starts phase 0 in the next clock period.
- R9: The stretch setting is written through `cfg_we`/`cfg_stretch`, and its reset value is 1 (L=24). A write takes effect only at the next access start and never changes an access already in progress.
- R10: While `rst` is high and after it: `busy`, `done`, `ale` and `ad_oe` are 0, both strobes are 1, and `rdata`, `a_hi` and `ad_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an access (taken only when idle) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Last captured read byte |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |
| cfg_we | input | 1 | Load the stretch setting |
| cfg_stretch | input | 3 | New stretch setting S |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| a_hi | output | 8 | High address byte port |
| ad_o | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_i | input | 8 | Shared port input value |

## Verification
Every bus output is decoded from the phase counter and the captured access, so a wrong phase count or a wrong captured stretch value shows up within one clock. It appears as an edge of `ale`, a strobe or `ad_oe` one phase early or late, or as a `busy` length that does not match 8·(S+2). A wrong latch of the access shows on `a_hi` or `ad_o` from phase 1 or phase 2. A read captured on the wrong phase only appears in `rdata` after the strobe rises, so the shared input changes every clock to make any phase error visible. Changes to the setting in the middle of an access, and requests made while busy, are checked by the access length and by `busy` staying low after `done`.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int SEL_W      = 3;
    localparam int PH_PER_MC  = 8;   // phases per machine cycle
    localparam int BASE_MC    = 2;   // machine cycles at S = 0
    localparam int MAX_PH     = PH_PER_MC * (BASE_MC + (2 ** SEL_W) - 1);
    localparam int PH_W       = $clog2(MAX_PH + 1);

    // profile constants, in phases
    localparam int ALE_TIGHT   = 3;
    localparam int ALE_RELAXED = 4;
    localparam int FALL_TIGHT  = 4;
    localparam int FALL_RELAX  = 6;
    localparam int LOW_TIGHT   = 4;
    localparam int HOLD_TIGHT  = 2;
    localparam int HOLD_RELAX  = 4;
    localparam int HI_START    = 1;
    localparam int LO_START    = 2;

    localparam logic [SEL_W-1:0] SEL_RESET = SEL_W'(1);

    typedef struct packed {
        logic [PH_W-1:0] ale_end;
        logic [PH_W-1:0] strobe_fall;
        logic [PH_W-1:0] strobe_rise;
        logic [PH_W-1:0] data_end;
        logic [PH_W-1:0] last;
    } prof_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [SEL_W-1:0]  sel;
    } xfer_t;

    function automatic prof_t make_prof(input logic [SEL_W-1:0] sel);
        prof_t p;
        int    s;
        int    fall;
        int    rise;
        logic  tight;
        s      = int'(sel);
        tight  = (sel == '0);
        fall   = tight ? FALL_TIGHT : FALL_RELAX;
        rise   = fall + (tight ? LOW_TIGHT : PH_PER_MC * s);
        p.ale_end     = PH_W'(tight ? ALE_TIGHT : ALE_RELAXED);
        p.strobe_fall = PH_W'(fall);
        p.strobe_rise = PH_W'(rise);
        p.data_end    = PH_W'(rise + (tight ? HOLD_TIGHT : HOLD_RELAX));
        p.last        = PH_W'(PH_PER_MC * (BASE_MC + s) - 1);
        return p;
    endfunction

endpackage

// File: rtl/bus_seq_cfg.sv
module bus_seq_cfg
    import bus_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_val,
    output logic [SEL_W-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_RESET;
        end else if (wr_en) begin
            sel_q <= wr_val;
        end
    end

endmodule

// File: rtl/bus_seq_ctl.sv
module bus_seq_ctl
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  sel_cfg,
    input  logic [PH_W-1:0]   last_ph,
    output logic              active,
    output logic [PH_W-1:0]   phase,
    output xfer_t             cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= '0;
            cur    <= '0;
        end else if (!active) begin
            if (req) begin
                active    <= 1'b1;
                phase     <= '0;
                cur.we    <= we;
                cur.addr  <= addr;
                cur.wdata <= wdata;
                cur.sel   <= sel_cfg;
            end
        end else if (phase == last_ph) begin
            active <= 1'b0;
            phase  <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [PH_W-1:0]   phase,
    input  xfer_t             cur,
    input  prof_t             prof,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic [DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rdata
);

    logic strobe_win;
    logic lo_win;
    logic dat_win;
    logic capture;

    always_comb begin
        strobe_win = active && (phase >= prof.strobe_fall) && (phase < prof.strobe_rise);
        lo_win     = active && (phase >= PH_W'(LO_START)) && (phase < prof.strobe_fall);
        dat_win    = active && cur.we && (phase >= prof.strobe_fall) && (phase < prof.data_end);
        capture    = active && !cur.we && (phase == prof.strobe_rise - PH_W'(1));

        ale   = active && (phase < prof.ale_end);
        rd_n  = !(strobe_win && !cur.we);
        wr_n  = !(strobe_win && cur.we);
        done  = active && (phase == prof.last);
        a_hi  = (active && phase >= PH_W'(HI_START)) ? cur.addr[ADDR_W-1 -: DATA_W] : '0;
        ad_oe = lo_win || dat_win;
        if (lo_win) begin
            ad_o = cur.addr[DATA_W-1:0];
        end else if (dat_win) begin
            ad_o = cur.wdata;
        end else begin
            ad_o = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= ad_i;
        end
    end

endmodule

// File: rtl/bus_stretch_seq.sv
module bus_stretch_seq
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_stretch,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_i
);

    logic [SEL_W-1:0] sel_cfg;
    logic [SEL_W-1:0] cur_sel;
    logic [PH_W-1:0]  phase;
    logic             active;
    xfer_t            cur;
    prof_t            prof;

    assign cur_sel = cur.sel;
    assign prof    = make_prof(cur.sel);
    assign busy    = active;

    bus_seq_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_val (cfg_stretch),
        .sel_q  (sel_cfg)
    );

    bus_seq_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .sel_cfg (sel_cfg),
        .last_ph (prof.last),
        .active  (active),
        .phase   (phase),
        .cur     (cur)
    );

    bus_seq_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .phase  (phase),
        .cur    (cur),
        .prof   (prof),
        .ad_i   (ad_i),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .done   (done),
        .a_hi   (a_hi),
        .ad_o   (ad_o),
        .ad_oe  (ad_oe),
        .rdata  (rdata)
    );

endmodule

// File: rtl/bus_stretch_seq_chk.sv
module bus_stretch_seq_chk
    import bus_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ad_oe,
    input logic             done,
    input logic             busy,
    input logic [SEL_W-1:0] cur_sel
);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_ale_apart_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    p_read_float_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    p_wr_data_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> ad_oe);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && wr_n && !ale && !ad_oe));

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_sel));

endmodule

bind bus_stretch_seq bus_stretch_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .done    (done),
    .busy    (busy),
    .cur_sel (cur_sel)
);

// File: tb/bus_stretch_seq_bench.sv
module bus_stretch_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic        busy;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_stretch = '0;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  a_hi;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  ad_i = '0;

    int n_run  = 0;
    int n_fail = 0;
    int ncyc   = 0;

    always #10 clk = ~clk;

    bus_stretch_seq u_bus_stretch_seq (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done), .busy(busy), .cfg_we(cfg_we),
        .cfg_stretch(cfg_stretch), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .a_hi(a_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     rq, what, act, exp, ncyc);
        end
    endtask

    // timing formulas taken from the requirements, S = stretch setting
    function automatic int e_ale(input int s);  return (s == 0) ? 3 : 4; endfunction
    function automatic int e_fall(input int s); return (s == 0) ? 4 : 6; endfunction
    function automatic int e_rise(input int s);
        return e_fall(s) + ((s == 0) ? 4 : 8 * s);
    endfunction
    function automatic int e_dend(input int s);
        return e_rise(s) + ((s == 0) ? 2 : 4);
    endfunction
    function automatic int e_len(input int s); return 8 * (s + 2); endfunction

    // behavioural reference
    bit m_act = 0;
    int m_t = 0, m_sel = 0, m_cfg = 1, m_we = 0, m_addr = 0, m_wd = 0, m_rd = 0;
    bit check_on = 0;

    always @(posedge clk) begin
        ncyc++;
        if (rst) begin
            m_act = 0; m_t = 0; m_cfg = 1; m_rd = 0;
        end else begin
            if (m_act) begin
                if (m_we == 0 && m_t == e_rise(m_sel) - 1) m_rd = int'(ad_i);
                if (m_t == e_len(m_sel) - 1) m_act = 0;
                else m_t++;
            end else if (req) begin
                m_act = 1; m_t = 0; m_we = int'(we); m_addr = int'(addr);
                m_wd = int'(wdata); m_sel = m_cfg;
            end
            if (cfg_we) m_cfg = int'(cfg_stretch);
        end
    end

    always @(negedge clk) begin
        ad_i <= 8'((ncyc * 29 + 7) & 255);
        if (check_on) begin
            bit strobe, lo, dp;
            int exp_ado;
            strobe = m_act && m_t >= e_fall(m_sel) && m_t < e_rise(m_sel);
            lo = m_act && m_t >= 2 && m_t < e_fall(m_sel);
            dp = m_act && m_we == 1 && m_t >= e_fall(m_sel) && m_t < e_dend(m_sel);
            exp_ado = lo ? (m_addr & 255) : (dp ? m_wd : 0);
            chk("R2", "ale", 32'(ale), 32'(m_act && m_t < e_ale(m_sel)));
            chk("R3", "rd_n", 32'(rd_n), 32'(!(strobe && m_we == 0)));
            chk("R3", "wr_n", 32'(wr_n), 32'(!(strobe && m_we == 1)));
            chk("R4", "a_hi", 32'(a_hi), (m_act && m_t >= 1) ? 32'((m_addr >> 8) & 255) : 32'd0);
            chk("R4/R5", "ad_oe", 32'(ad_oe), 32'(lo || dp));
            chk("R4/R5", "ad_o", 32'(ad_o), 32'(exp_ado));
            chk("R6", "rdata", 32'(rdata), 32'(m_rd));
            chk("R7", "done", 32'(done), 32'(m_act && m_t == e_len(m_sel) - 1));
            chk("R7", "busy", 32'(busy), 32'(m_act));
        end
    end

    task automatic set_cfg(input int s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stretch = 3'(s);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one access; mid_cfg >= 0 rewrites the setting in the middle; poke sends
    // a second request while busy
    task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                          input int s, input int mid_cfg, input bit poke,
                          input string tag);
        int count;
        @(negedge clk);
        we = w; addr = a; wdata = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0; addr = ~a; wdata = ~d; we = ~w;
        count = 0;
        while (busy) begin
            count++;
            if (count == 5 && mid_cfg >= 0) begin
                cfg_we = 1'b1; cfg_stretch = 3'(mid_cfg);
            end else begin
                cfg_we = 1'b0;
            end
            if (count == 3 && poke) begin
                req = 1'b1; addr = 16'hBEEF; we = ~w;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; req = 1'b0;
        chk(tag, "busy length", 32'(count), 32'(e_len(s)));
        @(negedge clk);
        chk("R8", "no stray start", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "busy", 32'(busy), 32'd0);
        chk("R10", "done", 32'(done), 32'd0);
        chk("R10", "ale", 32'(ale), 32'd0);
        chk("R10", "rd_n", 32'(rd_n), 32'd1);
        chk("R10", "wr_n", 32'(wr_n), 32'd1);
        chk("R10", "ad_oe", 32'(ad_oe), 32'd0);
        chk("R10", "rdata", 32'(rdata), 32'd0);
        chk("R10", "a_hi", 32'(a_hi), 32'd0);
        rst = 1'b0;
        check_on = 1'b1;

        access(1'b0, 16'h12A5, 8'h00, 1, -1, 1'b0, "R9");
        access(1'b1, 16'h3C4B, 8'hE7, 1, -1, 1'b0, "R1");
        set_cfg(0);
        access(1'b0, 16'hF00D, 8'h00, 0, -1, 1'b0, "R1");
        access(1'b1, 16'h8001, 8'h5A, 0, -1, 1'b1, "R1");
        set_cfg(7);
        access(1'b1, 16'h7FFE, 8'hC3, 7, -1, 1'b0, "R1");
        access(1'b0, 16'h0203, 8'h00, 7, -1, 1'b0, "R1");
        set_cfg(3);
        access(1'b0, 16'hA55A, 8'h00, 3, 5, 1'b0, "R9");
        access(1'b1, 16'h1357, 8'h99, 5, -1, 1'b1, "R9");
        set_cfg(2);
        access(1'b0, 16'hFFFF, 8'h00, 2, -1, 1'b1, "R8");
        set_cfg(0);
        access(1'b1, 16'h0000, 8'hFF, 0, -1, 1'b0, "R5");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule